// File: doc/BRIEF.md
# UART transmitter with FIFO buffering

This block turns parallel bytes into asynchronous serial frames. Bytes enter through a one-cycle write strobe. They are held in a 16-entry first-in first-out buffer, or in a single holding slot when buffering is switched off. A frame sequencer paced by a 16x oversampling tick sends them out one at a time. It adds a start bit, 5 to 8 data bits, an optional parity bit and 1, 1.5 or 2 stop bits. An external divisor supplies the tick.

Three status outputs tell the host when it may write. The holding-empty flag and the transmit-ready flag change only at fixed points inside a frame, eight ticks into a bit. The transmitter-empty flag reports that nothing is queued or in flight. A break input holds the line low for as long as it is set.

Top module: `uart_tx_fifo`

## Requirements
- R1: The line `txd` is high after reset and between frames. A frame is a low start bit, then the data bits least significant first, then the parity bit when enabled, then high stop bits. Every bit except a half stop bit lasts 16 ticks.
- R2: `cfg_len` sets the character length: code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the selected length are not sent.
- R3: When `cfg_par_en` is 1, a parity bit follows the data. With `cfg_par_odd` = 0 the number of ones across data and parity is even. With `cfg_par_odd` = 1 it is odd. When `cfg_par_en` is 0, no parity bit is sent.
- R4: With `cfg_stop2` = 0 the stop time is 16 ticks. With `cfg_stop2` = 1 it is 24 ticks for 5-bit characters and 32 ticks for other lengths.
- R5: With `cfg_fifo_en` = 1, up to 16 bytes are queued and sent in write order. A write while 16 bytes are queued is ignored, and `tx_ready` is low while the queue is full.
- R6: With `cfg_fifo_en` = 0, one byte waits in the holding slot. A write while the slot is occupied is ignored, and `tx_ready` drops on the write that fills the slot.
- R7: When a byte is written into an idle, empty transmitter, its start bit begins between 8 and 24 ticks after the write.
- R8: `thr_empty` is 1 after reset and clears on every accepted write. It sets exactly 8 ticks after the start of the stop bit of a character, provided that no byte is then waiting to be sent.
- R9: `tx_ready` is 1 after reset. Once it has dropped, it returns to 1 exactly 8 ticks after a start bit begins, provided that there is free room again.
- R10: `tx_empty` is 1 only when no byte is waiting and no frame is being sent. It is low from an accepted write until the last stop bit ends.
- R11: While `cfg_break` is 1, `txd` is low from the next clock on. Buffer state is untouched, and the line returns high one clock after `cfg_break` clears.
- R12: When a byte is waiting at the end of a stop bit, the next start bit begins on that same tick, with no idle time between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Byte to send |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| cfg_len | input | 2 | Character length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_stop2 | input | 1 | Long stop time select |
| cfg_fifo_en | input | 1 | 16-entry buffering when 1, single holding slot when 0 |
| cfg_break | input | 1 | Force line low |
| txd | output | 1 | Serial line |
| thr_empty | output | 1 | Nothing waiting to be sent |
| tx_empty | output | 1 | Nothing waiting and nothing in flight |
| tx_ready | output | 1 | Room for another write |

## Verification
A bit counter or shift register that slips corrupts the decoded character at `txd` within a single frame time, at most 192 ticks. A wrong tick count moves the next start edge of a back-to-back burst by a measurable number of ticks. A stale occupancy count shows at the next checkpoint, eight ticks into a start or stop bit. There `thr_empty` or `tx_ready` takes the wrong value, and a dropped or duplicated entry appears as an extra or missing frame. The bench decodes every frame against a queue of expected bytes and checks both status flags on the exact tick on either side of each checkpoint.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txst_e;
endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [uart_tx_pkg::BYTE_W-1:0] wr_data,
  input  logic                           fifo_en,
  input  logic                           pop,
  output logic                           accept,
  output logic [CW-1:0]                  count,
  output logic [uart_tx_pkg::BYTE_W-1:0] head
);
  logic [uart_tx_pkg::BYTE_W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cap;

  assign cap    = fifo_en ? CW'(DEPTH) : CW'(1);
  assign accept = wr_en && (cnt < cap);
  assign count  = cnt;
  assign head   = mem[rp];

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (accept) wp <= wp + 1'b1;
      if (pop)    rp <= rp + 1'b1;
      cnt <= cnt + CW'(accept) - CW'(pop);
    end
  end

  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (cnt >= cap) && !pop) |=> (cnt == $past(cnt)));

  // R5
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (cnt != '0));
endmodule

// File: rtl/utx_framer.sv
module utx_framer #(
  parameter int OVS  = 16,
  parameter int MARK = 8,
  parameter int LEAD = 8,
  localparam int SW = $clog2(2 * OVS) + 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           tick,
  input  logic                           have_data,
  input  logic [uart_tx_pkg::BYTE_W-1:0] head,
  input  logic [1:0]                     cfg_len,
  input  logic                           cfg_par_en,
  input  logic                           cfg_par_odd,
  input  logic                           cfg_stop2,
  output logic                           pop,
  output logic                           line_bit,
  output logic                           idle,
  output logic                           start_mark,
  output logic                           stop_mark
);
  import uart_tx_pkg::*;

  txst_e              st;
  logic [SW-1:0]      sub, stop_last_q, stop_last_d;
  logic [2:0]         bitn, last_q;
  logic [BYTE_W-1:0]  shreg, masked;
  logic               pen_q, par_q;
  logic               bit_end, stop_end, lead_end, load;

  assign masked      = head & (8'hFF >> (2'd3 - cfg_len));
  assign stop_last_d = !cfg_stop2        ? SW'(OVS - 1) :
                       (cfg_len == 2'd0) ? SW'(OVS + OVS / 2 - 1) :
                                           SW'(2 * OVS - 1);

  assign bit_end  = tick && (sub == SW'(OVS - 1));
  assign stop_end = tick && (sub == stop_last_q);
  assign lead_end = tick && (sub == SW'(LEAD - 1));
  assign load     = ((st == ST_WAIT) && lead_end) ||
                    ((st == ST_STOP) && stop_end && have_data);

  assign pop        = load;
  assign idle       = (st == ST_IDLE);
  assign start_mark = tick && (st == ST_START) && (sub == SW'(MARK - 1));
  assign stop_mark  = tick && (st == ST_STOP)  && (sub == SW'(MARK - 1));

  always_comb begin
    case (st)
      ST_START:  line_bit = 1'b0;
      ST_DATA:   line_bit = shreg[0];
      ST_PARITY: line_bit = par_q;
      default:   line_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      sub         <= '0;
      bitn        <= '0;
      last_q      <= 3'd7;
      shreg       <= '0;
      pen_q       <= 1'b0;
      par_q       <= 1'b0;
      stop_last_q <= SW'(OVS - 1);
    end else if (load) begin
      st          <= ST_START;
      sub         <= '0;
      shreg       <= masked;
      last_q      <= 3'd4 + {1'b0, cfg_len};
      pen_q       <= cfg_par_en;
      par_q       <= (^masked) ^ cfg_par_odd;
      stop_last_q <= stop_last_d;
    end else begin
      case (st)
        ST_IDLE: if (have_data) begin
          st  <= ST_WAIT;
          sub <= '0;
        end
        ST_WAIT: if (tick) sub <= sub + 1'b1;
        ST_START: begin
          if (bit_end) begin
            st   <= ST_DATA;
            sub  <= '0;
            bitn <= '0;
          end else if (tick) sub <= sub + 1'b1;
        end
        ST_DATA: begin
          if (bit_end) begin
            sub   <= '0;
            shreg <= shreg >> 1;
            if (bitn == last_q) st <= pen_q ? ST_PARITY : ST_STOP;
            else                bitn <= bitn + 1'b1;
          end else if (tick) sub <= sub + 1'b1;
        end
        ST_PARITY: begin
          if (bit_end) begin
            st  <= ST_STOP;
            sub <= '0;
          end else if (tick) sub <= sub + 1'b1;
        end
        ST_STOP: begin
          if (stop_end) begin
            st  <= ST_IDLE;
            sub <= '0;
          end else if (tick) sub <= sub + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7
  lead_path_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |=> (st == ST_WAIT || st == ST_START));
endmodule

// File: rtl/utx_status.sv
module utx_status #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          pop,
  input  logic [CW-1:0] count,
  input  logic          fifo_en,
  input  logic          idle,
  input  logic          start_mark,
  input  logic          stop_mark,
  output logic          thr_empty,
  output logic          tx_empty,
  output logic          tx_ready
);
  logic [CW-1:0] nxt, cap;

  assign nxt = count + CW'(accept) - CW'(pop);
  assign cap = fifo_en ? CW'(DEPTH) : CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_empty <= 1'b1;
      tx_empty  <= 1'b1;
      tx_ready  <= 1'b1;
    end else begin
      if (accept)                        thr_empty <= 1'b0;
      else if (stop_mark && nxt == '0)   thr_empty <= 1'b1;

      if (nxt >= cap)                    tx_ready <= 1'b0;
      else if (start_mark)               tx_ready <= 1'b1;

      tx_empty <= (count == '0) && idle && !accept;
    end
  end

  // R8
  thre_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(thr_empty) |-> $past(stop_mark));

  // R9
  rdy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_ready) |-> $past(start_mark));
endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int OVS   = 16,
  parameter int MARK  = 8,
  parameter int LEAD  = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       tick16,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_stop2,
  input  logic       cfg_fifo_en,
  input  logic       cfg_break,
  output logic       txd,
  output logic       thr_empty,
  output logic       tx_empty,
  output logic       tx_ready
);
  logic          accept, pop, line_bit, idle, start_mark, stop_mark;
  logic [CW-1:0] count;
  logic [7:0]    head;

  utx_fifo #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_en(cfg_fifo_en), .pop(pop), .accept(accept),
    .count(count), .head(head)
  );

  utx_framer #(.OVS(OVS), .MARK(MARK), .LEAD(LEAD)) u_frm (
    .clk(clk), .rst(rst), .tick(tick16), .have_data(count != '0),
    .head(head), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2), .pop(pop),
    .line_bit(line_bit), .idle(idle), .start_mark(start_mark),
    .stop_mark(stop_mark)
  );

  utx_status #(.DEPTH(DEPTH)) u_sts (
    .clk(clk), .rst(rst), .accept(accept), .pop(pop), .count(count),
    .fifo_en(cfg_fifo_en), .idle(idle), .start_mark(start_mark),
    .stop_mark(stop_mark), .thr_empty(thr_empty), .tx_empty(tx_empty),
    .tx_ready(tx_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) txd <= 1'b1;
    else     txd <= cfg_break ? 1'b0 : line_bit;
  end

  // R11
  brk_low_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_break |=> !txd);

  // R10
  empty_order_chk: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> thr_empty);
endmodule

// File: tb/sim_uart_tx_fifo.sv
module sim_uart_tx_fifo;
  typedef struct {
    logic [7:0] d;
    int nb, stl, wt;
    bit pe, po, idl, b2b, ct, cr;
  } item_t;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, tick = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] cfg_len = 2'd3;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_stop2 = 0, cfg_fifo_en = 0, cfg_break = 0;
  logic txd, thr_empty, tx_empty, tx_ready;
  int tick_cnt = 0, ph = 0, checks = 0, fails = 0;
  bit mon_off = 0;
  item_t q[$];

  always #5 clk = ~clk;

  uart_tx_fifo u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .tick16(tick),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .cfg_fifo_en(cfg_fifo_en), .cfg_break(cfg_break),
    .txd(txd), .thr_empty(thr_empty), .tx_empty(tx_empty), .tx_ready(tx_ready)
  );

  always @(negedge clk) begin
    ph   <= (ph + 1) % 4;
    tick <= (ph == 3);
  end
  always @(posedge clk) if (tick) tick_cnt <= tick_cnt + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wt(input int t);
    while (tick_cnt < t) @(negedge clk);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Driver: one write per call, consecutive calls give consecutive cycles.
  task automatic wr(input logic [7:0] d, input bit push, input bit idl,
                    input bit b2b, input bit ct, input bit cr);
    item_t it;
    wr_en   = 1'b1;
    wr_data = d;
    if (push) begin
      it.d   = d;
      it.nb  = 5 + int'(cfg_len);
      it.pe  = cfg_par_en;
      it.po  = cfg_par_odd;
      it.stl = !cfg_stop2 ? 16 : (cfg_len == 0 ? 24 : 32);
      it.wt  = tick_cnt;
      it.idl = idl; it.b2b = b2b; it.ct = ct; it.cr = cr;
      q.push_back(it);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drain();
    while (!(q.size() == 0 && tx_empty)) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  // Monitor: decodes txd and compares with the expected queue.
  initial begin
    int s, ss, last_end;
    item_t it;
    logic [7:0] got, exp_d;
    logic ep;
    last_end = -1000;
    forever begin
      @(negedge clk);
      if (!rst && !mon_off && txd === 1'b0) begin
        s = tick_cnt;
        if (q.size() == 0) begin
          chk(0, "R5 R6 unexpected frame", s, -1);
          while (txd !== 1'b1) @(negedge clk);
        end else begin
          it = q.pop_front();
          if (it.idl) chk((s - it.wt) >= 8 && (s - it.wt) <= 24, "R7 start latency", s - it.wt, 8);
          if (it.b2b) chk(s == last_end, "R12 R4 back-to-back start tick", s, last_end);
          if (it.cr) begin
            wt(s + 7); chk(tx_ready == 1'b0, "R9 ready before start mark", tx_ready, 0);
            wt(s + 8); chk(tx_ready == 1'b1, "R9 ready at start mark", tx_ready, 1);
          end
          wt(s + 8); chk(txd == 1'b0, "R1 start bit low", txd, 0);
          got = '0;
          for (int i = 0; i < it.nb; i++) begin
            wt(s + 16 * (i + 1) + 8);
            got[i] = txd;
          end
          exp_d = it.d & 8'((1 << it.nb) - 1);
          chk(got == exp_d, "R2 data bits", got, exp_d);
          ss = s + 16 * (1 + it.nb + int'(it.pe));
          if (it.pe) begin
            ep = (^exp_d) ^ it.po;
            wt(ss - 8); chk(txd == ep, "R3 parity bit", txd, ep);
          end
          if (it.ct) begin
            wt(ss + 7); chk(thr_empty == 1'b0, "R8 holding flag before stop mark", thr_empty, 0);
          end
          wt(ss + 8); chk(txd == 1'b1, "R1 stop bit high", txd, 1);
          if (it.ct) begin
            chk(thr_empty == 1'b1, "R8 holding flag at stop mark", thr_empty, 1);
            chk(tx_empty == 1'b0, "R10 busy during stop", tx_empty, 0);
          end
          last_end = ss + it.stl;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R1 idle line after reset", txd, 1);
    chk(thr_empty == 1'b1, "R8 reset value", thr_empty, 1);
    chk(tx_empty == 1'b1, "R10 reset value", tx_empty, 1);
    chk(tx_ready == 1'b1, "R9 reset value", tx_ready, 1);

    // Character mode, 8 bits, no parity, 1 stop
    wr(8'hA5, 1, 1, 0, 1, 1);
    chk(tx_ready == 1'b0, "R6 ready drops on fill", tx_ready, 0);
    chk(thr_empty == 1'b0, "R8 cleared by write", thr_empty, 0);
    chk(tx_empty == 1'b0, "R10 cleared by write", tx_empty, 0);
    drain();

    // Character mode: second write while slot occupied is dropped (R6)
    wr(8'h3C, 1, 1, 0, 1, 0);
    wr(8'hFF, 0, 0, 0, 0, 0);
    chk(tx_ready == 1'b0, "R6 ready low while occupied", tx_ready, 0);
    drain();

    // FIFO, 7 bits, even parity, 1 stop
    cfg_fifo_en = 1; cfg_len = 2'd2; cfg_par_en = 1; cfg_par_odd = 0;
    wr(8'h55, 1, 1, 0, 0, 0);
    wr(8'h0F, 1, 0, 1, 0, 0);
    wr(8'hFF, 1, 0, 1, 0, 0);
    wr(8'h01, 1, 0, 1, 1, 0);
    drain();

    // FIFO, 5 bits, odd parity, 1.5 stop
    cfg_len = 2'd0; cfg_par_odd = 1; cfg_stop2 = 1;
    wr(8'h15, 1, 1, 0, 0, 0);
    wr(8'h0A, 1, 0, 1, 0, 0);
    wr(8'h1F, 1, 0, 1, 1, 0);
    drain();

    // FIFO, 6 bits, no parity, 2 stop
    cfg_len = 2'd1; cfg_par_en = 0;
    wr(8'h2A, 1, 1, 0, 0, 0);
    wr(8'h15, 1, 0, 1, 0, 0);
    wr(8'h3F, 1, 0, 1, 1, 0);
    drain();

    // FIFO fill to 16 plus one ignored write (R5)
    cfg_len = 2'd3; cfg_stop2 = 0;
    for (int i = 0; i < 17; i++)
      wr(8'(i * 37 + 1), i < 16, i == 0, i > 0, i == 15, i == 0);
    chk(tx_ready == 1'b0, "R5 ready low when full", tx_ready, 0);
    drain();

    // Break (R11)
    mon_off = 1;
    cfg_break = 1;
    repeat (2) @(negedge clk);
    chk(txd == 1'b0, "R11 break forces low", txd, 0);
    chk(tx_empty == 1'b1, "R11 break leaves state", tx_empty, 1);
    cfg_break = 0;
    repeat (2) @(negedge clk);
    chk(txd == 1'b1, "R11 line released", txd, 1);
    mon_off = 0;

    repeat (200) @(negedge clk);
    chk(q.size() == 0, "R5 R6 all expected frames seen", q.size(), 0);
    summary();
    $finish;
  end
endmodule